// File: doc/BRIEF.md
# UART Host Register Interface Decoder

This block sits between a host processor bus and the register file of a 16450-class serial port. It decides when the part is selected from three select inputs of mixed polarity. It holds the register offset in a strobe-gated latch. It accepts read and write commands on either an active-high or an active-low strobe, and it turns each host access into a one-cycle enable for the addressed register.

The block owns the line control register, the scratch register and the two divisor bytes. The top bit of the line control register switches offsets 0 and 1 between the data and interrupt-enable registers and the divisor bytes. Registers that belong to the serial engines and to interrupt logic reach the read multiplexer through input ports, and their writes leave as enables alongside the captured write data.

The design is fully synchronous to `clk` and has a synchronous active-high master reset. All outputs are registered, so every effect of an access shows up one clock after the cycle in which the block samples it.

Top module: `uart_host_if`

## Requirements
- R1: `cs_out` is 1 in the cycle after a clock edge at which `sel_a`=1, `sel_b`=1 and `sel_c_n`=0 all held together, and 0 after any other edge.
- R2: While `adr_stb_n`=0 the effective offset follows `adr` directly. After `adr_stb_n` rises, the offset last seen while it was low is used until the strobe goes low again.
- R3: A read is active when the part is selected and either `rd_h`=1 or `rd_l_n`=0. One clock later `drv_dis`=1 and `rd_data` carries the addressed register. When no read is active, `drv_dis`=0 and `rd_data`=0x00.
- R4: A write is active when the part is selected and either `wr_h`=1 or `wr_l_n`=0. Each rising edge of write-active gives exactly one write. It raises one bit of `wr_stb` for exactly one cycle and latches `din` on `wr_data`. Likewise, each rising edge of read-active raises one bit of `rd_stb` for one cycle. Strobe bit encoding: 0 data, 1 interrupt enable, 2 interrupt id, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 divisor low, 9 divisor high.
- R5: With bit 7 of the line control register at 1, offsets 0 and 1 reach the divisor low and high bytes. With that bit at 0, offset 0 reaches the data register and offset 1 reaches interrupt enable.
- R6: Offsets 2 to 7 reach interrupt id, line control, modem control, line status, modem status and scratch respectively, independent of bit 7.
- R7: A write to offset 2 raises no `wr_stb` bit and changes no register in the block.
- R8: Reset clears line control, scratch, the held offset and all outputs. The divisor bytes keep their values through reset.
- R9: With the select condition not met, read and write strobes have no effect.
- R10: When a read and a write are active together, the read returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| sel_a | input | 1 | Select input, active high |
| sel_b | input | 1 | Select input, active high |
| sel_c_n | input | 1 | Select input, active low |
| adr_stb_n | input | 1 | Address strobe, latch transparent while low |
| adr | input | 3 | Register offset |
| rd_h | input | 1 | Read strobe, active high |
| rd_l_n | input | 1 | Read strobe, active low |
| wr_h | input | 1 | Write strobe, active high |
| wr_l_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| rbr_i | input | 8 | Receive data register value |
| ier_i | input | 8 | Interrupt enable register value |
| iir_i | input | 8 | Interrupt id register value |
| mcr_i | input | 8 | Modem control register value |
| lsr_i | input | 8 | Line status register value |
| msr_i | input | 8 | Modem status register value |
| rd_data | output | 8 | Read data, 0x00 when idle |
| drv_dis | output | 1 | High while the host reads |
| cs_out | output | 1 | Select condition met |
| wr_stb | output | 10 | One-cycle write enables per register |
| rd_stb | output | 10 | One-cycle read enables per register |
| wr_data | output | 8 | Data of the last write |
| lcr_o | output | 8 | Line control register |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |

## Verification
A read and a write can be active in the same cycle. The case that matters is a write to line control that flips the bank bit while offset 0 or offset 3 is being read. The bench starts both strobes on the same clock edge. It expects the read data to show the line control value and bank mapping from before the write, and the new value on the following read. A behavioural model updated on every edge judges this collision together with every other output.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  typedef enum logic [3:0] {
    DST_DATA = 4'd0,
    DST_IER  = 4'd1,
    DST_IIR  = 4'd2,
    DST_LCR  = 4'd3,
    DST_MCR  = 4'd4,
    DST_LSR  = 4'd5,
    DST_MSR  = 4'd6,
    DST_SCR  = 4'd7,
    DST_DLL  = 4'd8,
    DST_DLM  = 4'd9
  } dest_e;
  localparam int NDEST = 10;
endpackage

// File: rtl/uart_bus_qual.sv
module uart_bus_qual (
  input  logic clk,
  input  logic rst,
  input  logic sel_a,
  input  logic sel_b,
  input  logic sel_c_n,
  input  logic rd_h,
  input  logic rd_l_n,
  input  logic wr_h,
  input  logic wr_l_n,
  output logic sel,
  output logic rd_act,
  output logic wr_act,
  output logic rd_go,
  output logic wr_go
);
  logic rd_q, wr_q;

  assign sel    = sel_a & sel_b & ~sel_c_n;
  assign rd_act = sel & (rd_h | ~rd_l_n);
  assign wr_act = sel & (wr_h | ~wr_l_n);
  assign rd_go  = rd_act & ~rd_q;
  assign wr_go  = wr_act & ~wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end
endmodule

// File: rtl/uart_addr_hold.sv
module uart_addr_hold #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff
);
  logic [AW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (!stb_n) held <= addr_in;
  end

  assign addr_eff = stb_n ? held : addr_in;
endmodule

// File: rtl/uart_dest_decode.sv
module uart_dest_decode
  import uart_host_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          bank,
  output dest_e         dest
);
  always_comb begin
    case (addr)
      AW'(0):  dest = bank ? DST_DLL : DST_DATA;
      AW'(1):  dest = bank ? DST_DLM : DST_IER;
      AW'(2):  dest = DST_IIR;
      AW'(3):  dest = DST_LCR;
      AW'(4):  dest = DST_MCR;
      AW'(5):  dest = DST_LSR;
      AW'(6):  dest = DST_MSR;
      default: dest = DST_SCR;
    endcase
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  dest_e         dest,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lcr,
  output logic [DW-1:0] scr,
  output logic [DW-1:0] dll,
  output logic [DW-1:0] dlm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr <= '0;
      scr <= '0;
    end else if (wr_go) begin
      if (dest == DST_LCR) lcr <= wdata;
      if (dest == DST_SCR) scr <= wdata;
    end
  end

  // divisor bytes are outside the reset domain
  always_ff @(posedge clk) begin
    if (wr_go && dest == DST_DLL) dll <= wdata;
    if (wr_go && dest == DST_DLM) dlm <= wdata;
  end
endmodule

// File: rtl/uart_host_if.sv
module uart_host_if
  import uart_host_pkg::*;
#(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int BANK_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adr_stb_n,
  input  logic [AW-1:0]    adr,
  input  logic             rd_h,
  input  logic             rd_l_n,
  input  logic             wr_h,
  input  logic             wr_l_n,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    rbr_i,
  input  logic [DW-1:0]    ier_i,
  input  logic [DW-1:0]    iir_i,
  input  logic [DW-1:0]    mcr_i,
  input  logic [DW-1:0]    lsr_i,
  input  logic [DW-1:0]    msr_i,
  output logic [DW-1:0]    rd_data,
  output logic             drv_dis,
  output logic             cs_out,
  output logic [NDEST-1:0] wr_stb,
  output logic [NDEST-1:0] rd_stb,
  output logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    lcr_o,
  output logic [DW-1:0]    dll_o,
  output logic [DW-1:0]    dlm_o
);
  logic          sel, rd_act, wr_act, rd_go, wr_go;
  logic [AW-1:0] addr_eff;
  dest_e         dest;
  logic [DW-1:0] lcr, scr, dll, dlm;
  logic [DW-1:0] mux_q;
  logic [NDEST-1:0] wr_stb_d, rd_stb_d;

  uart_bus_qual u_qual (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_h(rd_h), .rd_l_n(rd_l_n), .wr_h(wr_h), .wr_l_n(wr_l_n),
    .sel(sel), .rd_act(rd_act), .wr_act(wr_act), .rd_go(rd_go), .wr_go(wr_go)
  );

  uart_addr_hold #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .stb_n(adr_stb_n), .addr_in(adr), .addr_eff(addr_eff)
  );

  uart_dest_decode #(.AW(AW)) u_dec (
    .addr(addr_eff), .bank(lcr[BANK_BIT]), .dest(dest)
  );

  uart_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_go(wr_go), .dest(dest), .wdata(din),
    .lcr(lcr), .scr(scr), .dll(dll), .dlm(dlm)
  );

  always_comb begin
    case (dest)
      DST_DATA: mux_q = rbr_i;
      DST_IER:  mux_q = ier_i;
      DST_IIR:  mux_q = iir_i;
      DST_LCR:  mux_q = lcr;
      DST_MCR:  mux_q = mcr_i;
      DST_LSR:  mux_q = lsr_i;
      DST_MSR:  mux_q = msr_i;
      DST_SCR:  mux_q = scr;
      DST_DLL:  mux_q = dll;
      default:  mux_q = dlm;
    endcase
  end

  for (genvar g = 0; g < NDEST; g++) begin : g_stb
    if (g == int'(DST_IIR)) begin : g_ro
      assign wr_stb_d[g] = 1'b0;
    end else begin : g_rw
      assign wr_stb_d[g] = wr_go && (dest == dest_e'(g));
    end
    assign rd_stb_d[g] = rd_go && (dest == dest_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      drv_dis <= 1'b0;
      cs_out  <= 1'b0;
      wr_stb  <= '0;
      rd_stb  <= '0;
      wr_data <= '0;
    end else begin
      rd_data <= rd_act ? mux_q : '0;
      drv_dis <= rd_act;
      cs_out  <= sel;
      wr_stb  <= wr_stb_d;
      rd_stb  <= rd_stb_d;
      if (wr_go) wr_data <= din;
    end
  end

  assign lcr_o = lcr;
  assign dll_o = dll;
  assign dlm_o = dlm;

  // R1: select output tracks the qualified select one edge later
  a_r1_cs_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cs_out == $past(sel));

  // R3: idle bus returns zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !drv_dis |-> rd_data == '0);

  // R4: at most one enable, and only for one cycle
  a_r4_wr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb) && $onehot0(rd_stb));
  a_r4_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '0) |=> (wr_stb == '0));

  // R7: write to interrupt id leaves everything alone
  a_r7_iir_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_go && dest == DST_IIR) |=> (wr_stb == '0) && $stable(lcr_o));

  // R9: no strobe without select
  a_r9_no_sel: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (wr_stb == '0) && (rd_stb == '0) && !drv_dis);
endmodule

// File: tb/uart_host_if_test.sv
module uart_host_if_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_a = 0, sel_b = 0, sel_c_n = 1, adr_stb_n = 0;
  logic [2:0] adr = 0;
  logic rd_h = 0, rd_l_n = 1, wr_h = 0, wr_l_n = 1;
  logic [7:0] din = 0;
  logic [7:0] rbr_i = 8'h11, ier_i = 8'h22, iir_i = 8'h01,
              mcr_i = 8'h44, lsr_i = 8'h60, msr_i = 8'hB0;
  logic [7:0] rd_data, wr_data, lcr_o, dll_o, dlm_o;
  logic drv_dis, cs_out;
  logic [9:0] wr_stb, rd_stb;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #10 clk = ~clk;

  uart_host_if uut (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adr_stb_n(adr_stb_n), .adr(adr), .rd_h(rd_h), .rd_l_n(rd_l_n),
    .wr_h(wr_h), .wr_l_n(wr_l_n), .din(din), .rbr_i(rbr_i), .ier_i(ier_i),
    .iir_i(iir_i), .mcr_i(mcr_i), .lsr_i(lsr_i), .msr_i(msr_i),
    .rd_data(rd_data), .drv_dis(drv_dis), .cs_out(cs_out), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wr_data(wr_data), .lcr_o(lcr_o), .dll_o(dll_o),
    .dlm_o(dlm_o)
  );

  // behavioural reference
  logic [7:0] m_lcr, m_scr, m_dll, m_dlm, m_dout, m_wdata;
  logic [2:0] m_hold;
  logic [9:0] m_wst, m_rst;
  logic m_cs, m_ddis, m_wprev, m_rprev;

  function automatic int target(input int off, input bit bank);
    if (off == 0) return bank ? 8 : 0;
    if (off == 1) return bank ? 9 : 1;
    return off;
  endfunction

  always @(posedge clk) begin
    bit s, ra, wa;
    int off, t;
    logic [7:0] v;
    started = 1;
    s  = sel_a && sel_b && !sel_c_n;
    ra = s && (rd_h || !rd_l_n);
    wa = s && (wr_h || !wr_l_n);
    off = adr_stb_n ? int'(m_hold) : int'(adr);
    t = target(off, m_lcr[7]);
    case (t)
      0: v = rbr_i;  1: v = ier_i;  2: v = iir_i;  3: v = m_lcr;
      4: v = mcr_i;  5: v = lsr_i;  6: v = msr_i;  7: v = m_scr;
      8: v = m_dll;  default: v = m_dlm;
    endcase
    if (rst) begin
      m_lcr = 0; m_scr = 0; m_hold = 0; m_dout = 0; m_wdata = 0;
      m_wst = 0; m_rst = 0; m_cs = 0; m_ddis = 0; m_wprev = 0; m_rprev = 0;
    end else begin
      m_cs = s;
      m_ddis = ra;
      m_dout = ra ? v : 8'h00;
      m_rst = (ra && !m_rprev) ? (10'd1 << t) : 10'd0;
      m_wst = (wa && !m_wprev && t != 2) ? (10'd1 << t) : 10'd0;
      if (wa && !m_wprev) begin
        m_wdata = din;
        if (t == 3) m_lcr = din;
        if (t == 7) m_scr = din;
        if (t == 8) m_dll = din;
        if (t == 9) m_dlm = din;
      end
      if (!adr_stb_n) m_hold = adr;
      m_wprev = wa;
      m_rprev = ra;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R1 cs_out", 16'(cs_out), 16'(m_cs));
      chk("R3 drv_dis", 16'(drv_dis), 16'(m_ddis));
      chk("R3 rd_data", 16'(rd_data), 16'(m_dout));
      chk("R4 wr_stb", 16'(wr_stb), 16'(m_wst));
      chk("R4 rd_stb", 16'(rd_stb), 16'(m_rst));
      chk("R4 wr_data", 16'(wr_data), 16'(m_wdata));
      chk("R8 lcr", 16'(lcr_o), 16'(m_lcr));
      chk("R5 dll", 16'(dll_o), 16'(m_dll));
      chk("R5 dlm", 16'(dlm_o), 16'(m_dlm));
    end
  end

  task automatic select(input bit on);
    sel_a = on; sel_b = on; sel_c_n = !on;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit lowpol,
                    output logic [9:0] stb);
    @(negedge clk);
    select(1); adr = a; din = d;
    if (lowpol) wr_l_n = 0; else wr_h = 1;
    @(negedge clk);
    stb = wr_stb;
    wr_l_n = 1; wr_h = 0;
    @(negedge clk);
    select(0);
  endtask

  task automatic rd(input logic [2:0] a, input bit lowpol, output logic [7:0] q);
    @(negedge clk);
    select(1); adr = a;
    if (lowpol) rd_l_n = 0; else rd_h = 1;
    @(negedge clk);
    q = rd_data;
    rd_l_n = 1; rd_h = 0;
    @(negedge clk);
    select(0);
  endtask

  initial begin
    logic [7:0] q;
    logic [9:0] s;
    repeat (3) @(negedge clk);
    chk("R8 reset rd_data", 16'(rd_data), 16'h0);
    chk("R8 reset lcr", 16'(lcr_o), 16'h0);
    rst = 0;

    // banking: divisor bytes
    wr(3'd3, 8'h83, 0, s);
    chk("R4 lcr strobe bit3", 16'(s), 16'h008);
    wr(3'd0, 8'h34, 0, s);
    chk("R5 dll strobe bit8", 16'(s), 16'h100);
    wr(3'd1, 8'h12, 1, s);
    chk("R5 dlm strobe bit9", 16'(s), 16'h200);
    rd(3'd0, 1, q); chk("R5 read dll", 16'(q), 16'h34);
    rd(3'd1, 0, q); chk("R5 read dlm", 16'(q), 16'h12);

    // normal bank
    wr(3'd3, 8'h03, 1, s);
    rd(3'd0, 0, q); chk("R5 read data reg", 16'(q), 16'h11);
    rd(3'd1, 1, q); chk("R5 read ier", 16'(q), 16'h22);
    wr(3'd0, 8'h5C, 0, s);
    chk("R5 data strobe bit0", 16'(s), 16'h001);
    chk("R4 wr_data", 16'(wr_data), 16'h5C);

    // fixed offsets
    rd(3'd2, 0, q); chk("R6 iir", 16'(q), 16'h01);
    rd(3'd3, 0, q); chk("R6 lcr", 16'(q), 16'h03);
    rd(3'd4, 1, q); chk("R6 mcr", 16'(q), 16'h44);
    rd(3'd5, 0, q); chk("R6 lsr", 16'(q), 16'h60);
    rd(3'd6, 1, q); chk("R6 msr", 16'(q), 16'hB0);
    wr(3'd7, 8'hA5, 0, s);
    rd(3'd7, 0, q); chk("R6 scratch", 16'(q), 16'hA5);

    // read-only offset
    wr(3'd2, 8'hFF, 0, s);
    chk("R7 iir write no strobe", 16'(s), 16'h0);
    chk("R7 lcr untouched", 16'(lcr_o), 16'h03);

    // not selected
    @(negedge clk); adr = 3'd7; din = 8'h99; wr_h = 1; sel_a = 1; sel_b = 0; sel_c_n = 0;
    @(negedge clk); chk("R9 no strobe", 16'(wr_stb), 16'h0);
    chk("R1 cs low", 16'(cs_out), 16'h0);
    wr_h = 0; select(0);
    rd(3'd7, 0, q); chk("R9 scratch kept", 16'(q), 16'hA5);

    // address latch
    @(negedge clk); adr_stb_n = 0; adr = 3'd7;
    @(negedge clk); adr_stb_n = 1; adr = 3'd3;
    @(negedge clk); select(1); din = 8'h5A; wr_h = 1;
    @(negedge clk); chk("R2 latched offset strobe", 16'(wr_stb), 16'h080);
    wr_h = 0;
    @(negedge clk); select(0); adr_stb_n = 0;
    rd(3'd7, 0, q); chk("R2 scratch via latch", 16'(q), 16'h5A);

    // read and write together
    @(negedge clk); select(1); adr = 3'd3; din = 8'h80; rd_h = 1; wr_l_n = 0;
    @(negedge clk); chk("R10 old value read", 16'(rd_data), 16'h03);
    wr_l_n = 1; rd_h = 0;
    @(negedge clk); select(0);
    rd(3'd3, 0, q); chk("R10 new value", 16'(q), 16'h80);

    // reset keeps divisor
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R8 lcr cleared", 16'(lcr_o), 16'h0);
    rd(3'd7, 0, q); chk("R8 scratch cleared", 16'(q), 16'h0);
    wr(3'd3, 8'h80, 0, s);
    rd(3'd0, 0, q); chk("R8 dll kept", 16'(q), 16'h34);
    rd(3'd1, 1, q); chk("R8 dlm kept", 16'(q), 16'h12);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule